// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This controller sits between a processor-side request port and one DRAM device. Each request carries a word address. The controller splits that address into a row part and a column part. Both parts travel on one shared address bus: the row goes out with a row-open strobe, and the column follows later with a column strobe. After an access the row stays open, so a later access to the same row costs only one column command. An access to any other row first closes the open row.

A free-running interval timer raises a refresh demand at a fixed period. When the access in flight has finished, the demand takes priority over new requests. The controller then closes any open row and issues a refresh command. The recovery time of that command is kept far below the refresh period.

Read data comes back on a one-cycle valid pulse, in request order. The processor port stalls by holding ready low while a row change or a refresh is in progress.

Top module: `dram_page_ctrl`

## Requirements
- R1: The row is address bits [27:14], sent on the shared bus with the activate command. The column is bits [13:0], sent with the read or write command. Command pins {row_stb_n, col_stb_n, wr_n}: 111 idle, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh.
- R2: An activate is issued only when no row is open, and no sooner than T_RP cycles after the last precharge. A request to a row other than the open one is preceded by a precharge.
- R3: A read or write is issued only while a row is open, and no sooner than T_RCD cycles after that row's activate.
- R4: A request accepted while its row is already open produces its read or write command in the very next cycle, with no precharge and no activate. Consecutive same-row requests are accepted on consecutive cycles.
- R5: rd_valid is high for exactly one cycle, T_CL+1 cycles after each read command. In that cycle rd_data holds the word the device returned. Reads complete in request order and with the last written value.
- R6: mem_dq_oe is high only in the cycle of a write command, and mem_dq_o then holds that request's write data.
- R7: A refresh is issued only with no row open, and at most REF_INTERVAL+2*T_RP+T_RCD+4 cycles after the previous one. No activate follows a refresh sooner than T_RFC cycles.
- R8: Refresh occupies less than 5% of clock cycles. Parameter sets with 20*(T_RFC+T_RP) >= REF_INTERVAL are rejected at elaboration.
- R9: req_ready is low in every cycle that carries a precharge, activate or refresh command, and from a row-miss acceptance until that request's column command. A pending refresh is issued before any new request is accepted.
- R10: During reset all strobes are high (idle), req_ready is high, and rd_valid and mem_dq_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Word address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted at this edge when valid |
| rd_valid | output | 1 | One-cycle read data pulse |
| rd_data | output | 16 | Read data |
| mem_row_stb_n | output | 1 | Row strobe, active low |
| mem_col_stb_n | output | 1 | Column strobe, active low |
| mem_wr_n | output | 1 | Write enable, active low |
| mem_addr | output | 14 | Multiplexed row/column address |
| mem_dq_o | output | 16 | Data toward device |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_i | input | 16 | Data from device |

## Verification
The controller is driven with several request patterns:
- runs of same-row requests, which show whether page hits avoid activates and stream one per cycle;
- alternating rows, which expose missing precharges and short row-to-column gaps;
- the highest and lowest row and column values, which catch swapped or shifted address halves;
- long idle stretches, which show refresh spacing without traffic interfering.

A mixed pseudo-random stream over three rows and sixteen columns then puts refresh demands in the middle of row changes. A behavioural device model and a shadow copy of memory check every read value and the exact cycle of every read pulse.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // command value equals {row_stb_n, col_stb_n, wr_n}
  typedef enum logic [2:0] {
    C_NOP = 3'b111,
    C_ACT = 3'b011,
    C_RD  = 3'b101,
    C_WR  = 3'b100,
    C_PRE = 3'b010,
    C_REF = 3'b001
  } dpc_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_PREW,
    ST_ACTW,
    ST_REFW
  } dpc_state_e;

  function automatic int dpc_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // refresh work (recovery plus a closing precharge) must stay under 5%
  function automatic bit dpc_budget_ok(input int busy, input int interval);
    return (busy * 20) < interval;
  endfunction

endpackage

// File: rtl/dpc_refresh_timer.sv
module dpc_refresh_timer #(
  parameter int unsigned INTERVAL = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_due
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= CW'(INTERVAL - 1);
      ref_due <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q   <= CW'(INTERVAL - 1);
      ref_due <= 1'b1;
    end else begin
      cnt_q <= cnt_q - CW'(1);
      if (ref_ack) ref_due <= 1'b0;
    end
  end

  // R7
  due_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_due && !ref_ack |=> ref_due);

endmodule

// File: rtl/dpc_read_return.sv
module dpc_read_return #(
  parameter int DATA_W = 16,
  parameter int T_CL   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_rd,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [T_CL:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe_q   <= {pipe_q[T_CL-1:0], issue_rd};
      rd_valid <= pipe_q[T_CL];
      if (pipe_q[T_CL]) rd_data <= dq_in;
    end
  end

  // R5
  rd_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(pipe_q[T_CL]));

endmodule

// File: rtl/dpc_cmd_guard.sv
module dpc_cmd_guard #(
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 4,
  parameter int REF_LIMIT = 266
) (
  input logic clk,
  input logic rst_n,
  input logic row_stb_n,
  input logic col_stb_n,
  input logic wr_n,
  input logic req_ready
);
  localparam int SW = $clog2(REF_LIMIT + 2) + 1;

  logic [2:0] pins;
  logic is_act, is_pre, is_ref, is_col;
  logic bank_open, any_ref;
  logic [SW-1:0] s_act, s_pre, s_ref;

  assign pins   = {row_stb_n, col_stb_n, wr_n};
  assign is_act = (pins == 3'b011);
  assign is_pre = (pins == 3'b010);
  assign is_ref = (pins == 3'b001);
  assign is_col = (pins == 3'b101) || (pins == 3'b100);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open <= 1'b0;
      any_ref   <= 1'b0;
      s_act     <= '0;
      s_pre     <= SW'(T_RP);
      s_ref     <= '0;
    end else begin
      if (is_act) bank_open <= 1'b1;
      else if (is_pre) bank_open <= 1'b0;
      if (is_ref) any_ref <= 1'b1;
      s_act <= is_act ? SW'(1) : ((s_act == '1) ? s_act : s_act + SW'(1));
      s_pre <= is_pre ? SW'(1) : ((s_pre == '1) ? s_pre : s_pre + SW'(1));
      s_ref <= is_ref ? SW'(1) : ((s_ref == '1) ? s_ref : s_ref + SW'(1));
    end
  end

  // R2
  act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !bank_open);
  // R2
  act_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> s_pre >= SW'(T_RP));
  // R3
  col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> bank_open && s_act >= SW'(T_RCD));
  // R7
  ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> !bank_open);
  // R7
  act_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act && any_ref |-> s_ref >= SW'(T_RFC));
  // R7
  ref_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ref <= SW'(REF_LIMIT));
  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act || is_pre || is_ref) |-> !req_ready);

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int ADDR_W       = 28,
  parameter int ROW_W        = 14,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 2,
  parameter int T_CL         = 2,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 4,
  parameter int REF_INTERVAL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_row_stb_n,
  output logic              mem_col_stb_n,
  output logic              mem_wr_n,
  output logic [ROW_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  import dpc_pkg::*;

  localparam int COL_W     = ADDR_W - ROW_W;
  localparam int T_MAX     = dpc_max3(T_RCD, T_RP, T_RFC);
  localparam int CNT_W     = $clog2(T_MAX + 1);
  localparam int REF_LIMIT = REF_INTERVAL + 2 * T_RP + T_RCD + 4;

  if (!dpc_budget_ok(T_RFC + T_RP, REF_INTERVAL)) begin : g_budget_bad
    $error("refresh work exceeds 5 percent of the refresh interval");
  end
  if (COL_W > ROW_W || T_RCD < 1 || T_RP < 1 || T_RFC < 1 || T_CL < 1) begin : g_geom_bad
    $error("unsupported address split or timing parameter");
  end

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  function automatic logic [ROW_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return ROW_W'(a[COL_W-1:0]);
  endfunction

  dpc_state_e        state_q, nxt_state;
  logic [CNT_W-1:0]  cnt_q, nxt_cnt;
  logic              hold_valid_q, hold_write_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [DATA_W-1:0] hold_wdata_q;
  logic [ROW_W-1:0]  open_row_q;
  dpc_cmd_e          cmd_q, nxt_cmd;
  logic [ROW_W-1:0]  addr_q, nxt_addr;
  logic [DATA_W-1:0] dq_q, nxt_dq;
  logic              ld_hold, clr_hold, ref_ack, ref_due;
  logic              accept, hit, issue_rd;

  // named internal events
  assign req_ready = (state_q == ST_IDLE || state_q == ST_OPEN) && !hold_valid_q && !ref_due;
  assign accept    = req_valid && req_ready;
  assign hit       = (state_q == ST_OPEN) && (row_of(req_addr) == open_row_q);
  assign issue_rd  = (nxt_cmd == C_RD);

  always_comb begin
    nxt_state = state_q;
    nxt_cnt   = cnt_q;
    nxt_cmd   = C_NOP;
    nxt_addr  = '0;
    nxt_dq    = '0;
    ld_hold   = 1'b0;
    clr_hold  = 1'b0;
    ref_ack   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_due) begin
          nxt_cmd   = C_REF;
          nxt_state = ST_REFW;
          nxt_cnt   = CNT_W'(T_RFC - 1);
          ref_ack   = 1'b1;
        end else if (accept) begin
          nxt_cmd   = C_ACT;
          nxt_addr  = row_of(req_addr);
          nxt_state = ST_ACTW;
          nxt_cnt   = CNT_W'(T_RCD - 1);
          ld_hold   = 1'b1;
        end
      end
      ST_OPEN: begin
        if (ref_due) begin
          nxt_cmd   = C_PRE;
          nxt_state = ST_PREW;
          nxt_cnt   = CNT_W'(T_RP - 1);
        end else if (accept && hit) begin
          nxt_cmd  = req_write ? C_WR : C_RD;
          nxt_addr = col_of(req_addr);
          nxt_dq   = req_wdata;
        end else if (accept) begin
          nxt_cmd   = C_PRE;
          nxt_state = ST_PREW;
          nxt_cnt   = CNT_W'(T_RP - 1);
          ld_hold   = 1'b1;
        end
      end
      ST_PREW: begin
        if (cnt_q != '0) begin
          nxt_cnt = cnt_q - CNT_W'(1);
        end else if (hold_valid_q) begin
          nxt_cmd   = C_ACT;
          nxt_addr  = row_of(hold_addr_q);
          nxt_state = ST_ACTW;
          nxt_cnt   = CNT_W'(T_RCD - 1);
        end else begin
          nxt_state = ST_IDLE;
        end
      end
      ST_ACTW: begin
        if (cnt_q != '0) begin
          nxt_cnt = cnt_q - CNT_W'(1);
        end else begin
          nxt_cmd   = hold_write_q ? C_WR : C_RD;
          nxt_addr  = col_of(hold_addr_q);
          nxt_dq    = hold_wdata_q;
          nxt_state = ST_OPEN;
          clr_hold  = 1'b1;
        end
      end
      ST_REFW: begin
        if (cnt_q != '0) nxt_cnt = cnt_q - CNT_W'(1);
        else nxt_state = ST_IDLE;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      hold_valid_q <= 1'b0;
      hold_write_q <= 1'b0;
      hold_addr_q  <= '0;
      hold_wdata_q <= '0;
      open_row_q   <= '0;
      cmd_q        <= C_NOP;
      addr_q       <= '0;
      dq_q         <= '0;
    end else begin
      state_q <= nxt_state;
      cnt_q   <= nxt_cnt;
      cmd_q   <= nxt_cmd;
      addr_q  <= nxt_addr;
      dq_q    <= nxt_dq;
      if (ld_hold) begin
        hold_valid_q <= 1'b1;
        hold_write_q <= req_write;
        hold_addr_q  <= req_addr;
        hold_wdata_q <= req_wdata;
      end else if (clr_hold) begin
        hold_valid_q <= 1'b0;
      end
      if (nxt_cmd == C_ACT) open_row_q <= nxt_addr;
    end
  end

  assign {mem_row_stb_n, mem_col_stb_n, mem_wr_n} = 3'(cmd_q);
  assign mem_addr  = addr_q;
  assign mem_dq_o  = dq_q;
  assign mem_dq_oe = (cmd_q == C_WR);

  dpc_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_due(ref_due)
  );

  dpc_read_return #(.DATA_W(DATA_W), .T_CL(T_CL)) u_ret (
    .clk(clk), .rst_n(rst_n), .issue_rd(issue_rd), .dq_in(mem_dq_i),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  dpc_cmd_guard #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .REF_LIMIT(REF_LIMIT)) u_guard (
    .clk(clk), .rst_n(rst_n), .row_stb_n(mem_row_stb_n), .col_stb_n(mem_col_stb_n),
    .wr_n(mem_wr_n), .req_ready(req_ready)
  );

  // R4
  hit_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> (mem_col_stb_n == 1'b0) && mem_row_stb_n);
  // R9
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_due && state_q == ST_IDLE |=> !mem_row_stb_n && !mem_col_stb_n && mem_wr_n);

endmodule

// File: tb/sim_dram_page_ctrl.sv
module sim_dram_page_ctrl;
  localparam int TRCD = 2, TCL = 2, TRP = 2, TRFC = 4, RINT = 256;
  localparam int RBOUND = RINT + 2 * TRP + TRCD + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [27:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_row_stb_n, mem_col_stb_n, mem_wr_n, mem_dq_oe;
  logic [15:0] rd_data, mem_dq_o;
  logic [13:0] mem_addr;
  logic [15:0] dq_drv = '0;

  dram_page_ctrl #(.T_RCD(TRCD), .T_CL(TCL), .T_RP(TRP), .T_RFC(TRFC), .REF_INTERVAL(RINT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_row_stb_n(mem_row_stb_n),
    .mem_col_stb_n(mem_col_stb_n), .mem_wr_n(mem_wr_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(dq_drv)
  );

  always #4 clk = ~clk;

  typedef struct { bit w; logic [27:0] a; logic [15:0] d; } req_t;
  req_t busq[$];
  logic [15:0] rdq[$];
  logic [15:0] mem[int];
  logic [15:0] shadow[int];
  bit expv[16];
  logic [15:0] dpipe[16];
  int errors = 0, checks = 0, cyc = 0, acts = 0, refs = 0, last_ref = 0, wd = 0;
  int since_act = 1000, since_pre = 1000, since_ref = 1000;
  bit open_m = 0, any_ref = 0, exp_col_next = 0, miss_busy = 0;
  logic [13:0] orow_m = '0;

  function automatic logic [15:0] dflt(input logic [27:0] a);
    return a[15:0] ^ {a[27:20], a[7:0]} ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural device + protocol reference, sampled mid-cycle
  always @(negedge clk) if (rst_n) begin
    logic [2:0] cmd;
    req_t f;
    int key;
    cyc++; since_act++; since_pre++; since_ref++;
    for (int i = 0; i < 15; i++) begin expv[i] = expv[i+1]; dpipe[i] = dpipe[i+1]; end
    expv[15] = 0; dpipe[15] = '0;
    dq_drv = dpipe[0];
    check(rd_valid == expv[0], "R5 rd_valid cycle", rd_valid, expv[0]);
    if (rd_valid) begin
      if (rdq.size() == 0) check(0, "R5 unexpected read data", rd_data, 0);
      else begin
        logic [15:0] e;
        e = rdq.pop_front();
        check(rd_data == e, "R5 read data", rd_data, e);
      end
    end
    cmd = {mem_row_stb_n, mem_col_stb_n, mem_wr_n};
    if (exp_col_next) begin
      check(cmd == 3'b101 || cmd == 3'b100, "R4 hit column next cycle", cmd, 3'b101);
      exp_col_next = 0;
    end
    case (cmd)
      3'b011: begin
        check(!open_m, "R2 activate with row open", open_m, 0);
        check(since_pre >= TRP, "R2 precharge to activate", since_pre, TRP);
        check(since_ref >= TRFC, "R7 refresh to activate", since_ref, TRFC);
        check(!req_ready, "R9 ready during activate", req_ready, 0);
        if (busq.size() == 0) check(0, "R1 activate with no request", 0, 1);
        else check(mem_addr == busq[0].a[27:14], "R1 row half", mem_addr, busq[0].a[27:14]);
        open_m = 1; orow_m = mem_addr; since_act = 0; acts++;
        check(!mem_dq_oe, "R6 oe outside write", mem_dq_oe, 0);
      end
      3'b010: begin
        check(!req_ready, "R9 ready during precharge", req_ready, 0);
        open_m = 0; since_pre = 0;
        check(!mem_dq_oe, "R6 oe outside write", mem_dq_oe, 0);
      end
      3'b001: begin
        check(!open_m, "R7 refresh with row open", open_m, 0);
        check(!req_ready, "R9 ready during refresh", req_ready, 0);
        check((any_ref ? cyc - last_ref : cyc) <= RBOUND, "R7 refresh spacing",
              any_ref ? cyc - last_ref : cyc, RBOUND);
        any_ref = 1; last_ref = cyc; since_ref = 0; refs++;
        check(!mem_dq_oe, "R6 oe outside write", mem_dq_oe, 0);
      end
      3'b101, 3'b100: begin
        check(open_m, "R3 column with no open row", open_m, 1);
        check(since_act >= TRCD, "R3 activate to column", since_act, TRCD);
        if (busq.size() == 0) check(0, "R1 column with no request", 0, 1);
        else begin
          f = busq.pop_front();
          check(orow_m == f.a[27:14], "R1 open row matches request", orow_m, f.a[27:14]);
          check(mem_addr == f.a[13:0], "R1 column half", mem_addr, f.a[13:0]);
          check(cmd[0] == !f.w, "R1 command type", cmd, f.w ? 3'b100 : 3'b101);
          key = int'({orow_m, mem_addr});
          if (cmd == 3'b100) begin
            check(mem_dq_oe && mem_dq_o == f.d, "R6 write data", mem_dq_o, f.d);
            mem[key] = mem_dq_o;
          end else begin
            check(!mem_dq_oe, "R6 oe during read", mem_dq_oe, 0);
            expv[TCL+1] = 1;
            dpipe[TCL] = mem.exists(key) ? mem[key] : dflt(28'(key));
          end
        end
        miss_busy = 0;
      end
      default: check(!mem_dq_oe, "R6 oe while idle", mem_dq_oe, 0);
    endcase
    if (miss_busy) check(!req_ready, "R9 ready during row change", req_ready, 0);
    if (req_valid && req_ready) begin
      busq.push_back('{req_write, req_addr, req_wdata});
      if (req_write) shadow[int'(req_addr)] = req_wdata;
      else rdq.push_back(shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : dflt(req_addr));
      if (open_m && orow_m == req_addr[27:14]) exp_col_next = 1;
      else miss_busy = 1;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      errors++; checks++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", wd, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send(input bit w, input logic [27:0] a, input logic [15:0] d);
    bit acc;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
    end while (!acc);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      if (busq.size() == 0 && rdq.size() == 0) break;
      idle(1);
    end
    idle(TCL + 3);
  endtask

  initial begin
    int a0, t0;
    logic [31:0] lf;
    for (int i = 0; i < 16; i++) begin expv[i] = 0; dpipe[i] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ready, "R10 ready in reset", req_ready, 1);
    check({mem_row_stb_n, mem_col_stb_n, mem_wr_n} == 3'b111, "R10 strobes idle in reset",
          {mem_row_stb_n, mem_col_stb_n, mem_wr_n}, 3'b111);
    check(!rd_valid && !mem_dq_oe, "R10 valid and oe low in reset", {rd_valid, mem_dq_oe}, 0);
    @(posedge clk); #1; rst_n = 1;
    idle(2);

    // row opened from idle, then page hits
    for (int c = 5; c < 9; c++) send(1, {14'h0123, 14'(c)}, 16'h1000 + 16'(c));
    drain();
    check(acts == 1, "R4 one activate for same-row writes", acts, 1);
    a0 = acts; t0 = cyc;
    for (int c = 5; c < 9; c++) send(0, {14'h0123, 14'(c)}, '0);
    check(cyc - t0 == 4, "R4 back-to-back hit acceptance", cyc - t0, 4);
    drain();
    check(acts == a0, "R4 no activate on page hits", acts - a0, 0);

    // row changes need precharge + activate
    a0 = acts;
    send(1, {14'h2AAA, 14'h0000}, 16'hBEEF);
    send(0, {14'h0123, 14'h0006}, '0);
    send(0, {14'h2AAA, 14'h0000}, '0);
    drain();
    check(acts - a0 == 3, "R2 activate per row change", acts - a0, 3);

    // address extremes
    send(1, {14'h3FFF, 14'h3FFF}, 16'hA5A5);
    send(1, {14'h0000, 14'h0000}, 16'h5A5A);
    send(0, {14'h3FFF, 14'h3FFF}, '0);
    send(0, {14'h0000, 14'h0000}, '0);
    send(0, {14'h0000, 14'h3FFE}, '0);
    drain();

    // refresh during idle
    a0 = refs;
    idle(700);
    check(refs - a0 >= 2, "R7 refresh during idle", refs - a0, 2);

    // mixed traffic
    lf = 32'hACE1_1234;
    for (int n = 0; n < 400; n++) begin
      logic [13:0] row;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      row = (lf[11:10] == 2'd0) ? 14'h0123 : (lf[11:10] == 2'd1) ? 14'h2AAA : 14'h3FFF;
      send(lf[5], {row, 10'd0, lf[19:16]}, lf[31:16]);
      if (lf[9:7] == 3'd0) idle(int'(lf[3:2]) + 1);
    end
    drain();

    check(busq.size() == 0, "R5 all requests issued", busq.size(), 0);
    check(rdq.size() == 0, "R5 all reads returned", rdq.size(), 0);
    check(refs * TRFC * 100 < 5 * cyc, "R8 refresh share", refs * TRFC * 100, 5 * cyc);
    check(refs >= cyc / RBOUND, "R7 refresh count", refs, cyc / RBOUND);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule